// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Router

This block gathers up to 32 device interrupt lines and a set of software-raised levels for each processor. For every processor it drives a vector of 16 level lines, one line per interrupt level. Level 0 is never driven. Every level that has a live cause is asserted at the same time. The block does not encode only the highest level.

Device sources are held in a shared pending register and filtered by a shared disable register. A target register selects the one processor that receives them. Each source is given a level through a 4-bit-per-source table that is fixed when the block is built. Each processor also owns a software pending register, and its bits 17 to 31 stand for levels 1 to 15. A write port with four operations updates the state: clear software bits, set software bits, disable device sources, and set the target. All level outputs are registered. They always reflect the state that results from the most recent clock edge.

Top module: `irq_level_router`

## Requirements
- R1: While `rst_n` is low, every level output is 0. Reset clears device pending, selects processor 0 as target, and loads the disable register with 0x004DFF80. With this value, device sources 7 to 16, 18, 19 and 22 are blocked, and sources 0 to 6, 17, 20, 21 and 23 to 31 pass.
- R2: When device input j rises and its level L is nonzero, its pending bit is set. If source j is not disabled, line L of the target processor asserts. The default table gives L = j mod 16.
- R3: All active levels of a processor are asserted together. A level that two sources share stays asserted while either source is still active.
- R4: When a device input falls, its pending bit clears, and the level drops unless another cause still holds it.
- R5: Sources whose level is 0 never set pending. Line 0 of every processor is always 0.
- R6: `wr_op` = 2 (disable) ORs `wr_data` into the disable register and clears the same bits of device pending. A disabled source that rises again asserts nothing.
- R7: While bit 31 of the disable register is set, no device source reaches any processor. Software levels still assert.
- R8: `wr_op` = 3 (target) loads the target with `wr_data` masked to NUM_CPU-1. Device levels move to the new target and leave the old one.
- R9: `wr_op` = 1 (set) ORs bits 17 to 31 of `wr_data` into the software pending register of processor `wr_cpu`. Bit L+16 raises level L. Bits 0 to 16 of the write have no effect.
- R10: `wr_op` = 0 (clear) removes the selected bits 17 to 31 from the software pending register of processor `wr_cpu`. Bits 0 to 16 of the write have no effect.
- R11: A processor that is not the target shows exactly its own software levels.
- R12: A level line changes on the first clock edge that samples the causing write or input change. It does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq | input | 32 | Device interrupt levels, one per source |
| wr_en | input | 1 | Write strobe, one operation per cycle |
| wr_op | input | 2 | 0 clear soft, 1 set soft, 2 disable, 3 target |
| wr_cpu | input | CPU_W | Processor selected by soft set and clear |
| wr_data | input | 32 | Write operand |
| irq_lvl_o | output | NUM_CPU*16 | Level lines, processor i at bits i*16+15 : i*16 |

## Verification
A wrong internal state shows at the level lines on the cycle after the edge that stores it, because the outputs are computed from next-state values.

- A stale target puts device levels on the wrong processor in that cycle.
- A pending bit that was not cleared by a disable or a falling input keeps a level raised.
- A software bit written in the wrong position raises a neighbouring level, or a line-0 level.

Each scenario samples the lines one cycle after its stimulus and compares them with the whole expected vector of every processor it affects.

// File: rtl/irq_router_pkg.sv
// Package: shared constants, the write-operation encoding and the default
// source-to-level table for the interrupt level router.
package irq_router_pkg;
    localparam int SRC_N      = 32;
    localparam int LVL_N      = 16;
    localparam int LVL_W      = 4;
    localparam int GLOBAL_BIT = 31;
    localparam logic [SRC_N-1:0] SOFT_MASK  = 32'hfffe_0000;
    localparam logic [SRC_N-1:0] MDIS_RESET = ~32'hffb2_007f;

    typedef enum logic [1:0] {
        OP_CPU_CLR = 2'd0,
        OP_CPU_SET = 2'd1,
        OP_MST_DIS = 2'd2,
        OP_MST_TGT = 2'd3
    } wr_op_e;

    // Default table: source j raises level j mod 16.
    function automatic logic [SRC_N*LVL_W-1:0] default_level_map();
        logic [SRC_N*LVL_W-1:0] m;
        m = '0;
        for (int j = 0; j < SRC_N; j++) begin
            m[j*LVL_W +: LVL_W] = LVL_W'(j % LVL_N);
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_master_src.sv
// Module: irq_master_src
// Holds device pending, disable and target state. It produces the next-state
// values and the level vector that the device sources will present after the
// next edge.
// Assumes: NUM_CPU is a power of two, and at most one write operation per cycle.
module irq_master_src
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W = 2,
    parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = default_level_map()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] dev_irq,
    input  logic             wr_dis,
    input  logic             wr_tgt,
    input  logic [SRC_N-1:0] wr_data,
    output logic [SRC_N-1:0] mpend_q,
    output logic [SRC_N-1:0] mdis_q,
    output logic [CPU_W-1:0] tgt_q,
    output logic [CPU_W-1:0] tgt_d,
    output logic [LVL_N-1:0] master_lvl_d
);
    localparam logic [SRC_N-1:0] TGT_MASK = SRC_N'(NUM_CPU - 1);

    logic [SRC_N-1:0] dev_q;
    logic [SRC_N-1:0] lvl_nz;
    logic [SRC_N-1:0] rise;
    logic [SRC_N-1:0] fall;
    logic [SRC_N-1:0] mpend_d;
    logic [SRC_N-1:0] mdis_d;
    logic [SRC_N-1:0] mact_d;

    // Flags the sources whose table level is nonzero.
    for (genvar j = 0; j < SRC_N; j++) begin : g_nz
        assign lvl_nz[j] = |LEVEL_MAP[j*LVL_W +: LVL_W];
    end

    assign rise = dev_irq & ~dev_q & lvl_nz;
    assign fall = ~dev_irq & dev_q;

    // Next state: inputs first, then a disable write wins over a same-cycle rise.
    always_comb begin
        mpend_d = (mpend_q | rise) & ~fall;
        mdis_d  = mdis_q;
        tgt_d   = tgt_q;
        if (wr_dis) begin
            mpend_d = mpend_d & ~wr_data;
            mdis_d  = mdis_q | wr_data;
        end
        if (wr_tgt) begin
            tgt_d = CPU_W'(wr_data & TGT_MASK);
        end
    end

    assign mact_d = mpend_d & ~mdis_d & {SRC_N{~mdis_d[GLOBAL_BIT]}};

    // Turns the active sources into a level bitmask through the table.
    always_comb begin
        master_lvl_d = '0;
        for (int j = 0; j < SRC_N; j++) begin
            if (mact_d[j]) begin
                master_lvl_d[LEVEL_MAP[j*LVL_W +: LVL_W]] = 1'b1;
            end
        end
        master_lvl_d[0] = 1'b0;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q   <= '0;
            mpend_q <= '0;
            mdis_q  <= MDIS_RESET;
            tgt_q   <= '0;
        end else begin
            dev_q   <= dev_irq;
            mpend_q <= mpend_d;
            mdis_q  <= mdis_d;
            tgt_q   <= tgt_d;
        end
    end
endmodule

// File: rtl/irq_cpu_soft.sv
// Module: irq_cpu_soft
// Software pending register of one processor. Bits 17..31 map to levels 1..15.
// Assumes: set and clear never occur in the same cycle (a single op field).
module irq_cpu_soft
    import irq_router_pkg::*;
#(
    parameter int CPU_ID = 0,
    parameter int CPU_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_op,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [SRC_N-1:0] wr_data,
    output logic [SRC_N-1:0] soft_q,
    output logic [LVL_N-1:0] soft_lvl_d
);
    logic             sel;
    logic [SRC_N-1:0] soft_d;
    logic [SRC_N-1:0] wmask;

    assign sel   = wr_en && (wr_cpu == CPU_W'(CPU_ID));
    assign wmask = wr_data & SOFT_MASK;

    // Next software pending value for this processor.
    always_comb begin
        soft_d = soft_q;
        if (sel && wr_op_e'(wr_op) == OP_CPU_SET) begin
            soft_d = soft_q | wmask;
        end else if (sel && wr_op_e'(wr_op) == OP_CPU_CLR) begin
            soft_d = soft_q & ~wmask;
        end
    end

    assign soft_lvl_d = {soft_d[SRC_N-1:SRC_N-LVL_N+1], 1'b0};

    // Software pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= '0;
        end else begin
            soft_q <= soft_d;
        end
    end
endmodule

// File: rtl/irq_level_router.sv
// Module: irq_level_router (top)
// Routes device sources to the target processor and merges the software
// levels of each processor. It registers one level vector per processor,
// computed from next-state values so each line follows its cause by one edge.
// Assumes: NUM_CPU is a power of two.
module irq_level_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = default_level_map()
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SRC_N-1:0]         dev_irq,
    input  logic                     wr_en,
    input  logic [1:0]               wr_op,
    input  logic [CPU_W-1:0]         wr_cpu,
    input  logic [SRC_N-1:0]         wr_data,
    output logic [NUM_CPU*LVL_N-1:0] irq_lvl_o
);
    logic                            wr_dis;
    logic                            wr_tgt;
    logic [SRC_N-1:0]                mpend_q;
    logic [SRC_N-1:0]                mdis_q;
    logic [CPU_W-1:0]                tgt_q;
    logic [CPU_W-1:0]                tgt_d;
    logic [LVL_N-1:0]                master_lvl_d;
    logic [NUM_CPU-1:0][SRC_N-1:0]   soft_q;
    logic [NUM_CPU-1:0][LVL_N-1:0]   soft_lvl_d;
    logic [NUM_CPU*LVL_N-1:0]        lvl_d;

    assign wr_dis = wr_en && wr_op_e'(wr_op) == OP_MST_DIS;
    assign wr_tgt = wr_en && wr_op_e'(wr_op) == OP_MST_TGT;

    irq_master_src #(
        .NUM_CPU   (NUM_CPU),
        .CPU_W     (CPU_W),
        .LEVEL_MAP (LEVEL_MAP)
    ) u_master (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_irq      (dev_irq),
        .wr_dis       (wr_dis),
        .wr_tgt       (wr_tgt),
        .wr_data      (wr_data),
        .mpend_q      (mpend_q),
        .mdis_q       (mdis_q),
        .tgt_q        (tgt_q),
        .tgt_d        (tgt_d),
        .master_lvl_d (master_lvl_d)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        irq_cpu_soft #(
            .CPU_ID (i),
            .CPU_W  (CPU_W)
        ) u_soft (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en),
            .wr_op      (wr_op),
            .wr_cpu     (wr_cpu),
            .wr_data    (wr_data),
            .soft_q     (soft_q[i]),
            .soft_lvl_d (soft_lvl_d[i])
        );

        // Merges software levels with device levels when this processor is the target.
        assign lvl_d[i*LVL_N +: LVL_N] = soft_lvl_d[i] |
            ((tgt_d == CPU_W'(i)) ? master_lvl_d : {LVL_N{1'b0}});
    end

    // Output register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lvl_o <= '0;
        end else begin
            irq_lvl_o <= lvl_d;
        end
    end
endmodule

// File: rtl/irq_level_router_chk.sv
// Module: irq_level_router_chk
// Property checker bound to irq_level_router. It relates the output lines to
// the state registers held in separate submodules.
module irq_level_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic [1:0]                     wr_op,
    input logic [CPU_W-1:0]               wr_cpu,
    input logic [SRC_N-1:0]               wr_data,
    input logic [NUM_CPU*LVL_N-1:0]       irq_lvl_o,
    input logic [SRC_N-1:0]               mpend_q,
    input logic [SRC_N-1:0]               mdis_q,
    input logic [CPU_W-1:0]               tgt_q,
    input logic [NUM_CPU-1:0][SRC_N-1:0]  soft_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> irq_lvl_o == '0); // R1

    AST_DIS_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op_e'(wr_op) == OP_MST_DIS) |=> (mpend_q & $past(wr_data)) == '0); // R6

    AST_TGT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op_e'(wr_op) == OP_MST_TGT) |=> tgt_q == $past(wr_data[CPU_W-1:0])); // R8

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu_chk
        AST_LEVEL0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_lvl_o[i*LVL_N]); // R5

        AST_OFF_TARGET_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_q != CPU_W'(i)) |->
            irq_lvl_o[i*LVL_N +: LVL_N] == {soft_q[i][SRC_N-1:SRC_N-LVL_N+1], 1'b0}); // R11

        AST_GLOBAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            mdis_q[GLOBAL_BIT] |->
            irq_lvl_o[i*LVL_N +: LVL_N] == {soft_q[i][SRC_N-1:SRC_N-LVL_N+1], 1'b0}); // R7

        AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_op_e'(wr_op) == OP_CPU_CLR && wr_cpu == CPU_W'(i)) |=>
            (soft_q[i] & $past(wr_data) & SOFT_MASK) == '0); // R10
    end
endmodule

bind irq_level_router irq_level_router_chk #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_op     (wr_op),
    .wr_cpu    (wr_cpu),
    .wr_data   (wr_data),
    .irq_lvl_o (irq_lvl_o),
    .mpend_q   (mpend_q),
    .mdis_q    (mdis_q),
    .tgt_q     (tgt_q),
    .soft_q    (soft_q)
);

// File: tb/irq_level_router_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each task checks its own results.
module irq_level_router_bench;
    localparam int NCPU = 4;
    localparam int CW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     dev_irq = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_op = '0;
    logic [CW-1:0]   wr_cpu = '0;
    logic [31:0]     wr_data = '0;
    logic [NCPU*16-1:0] irq_lvl_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_level_router #(.NUM_CPU(NCPU)) u_irq_level_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq   (dev_irq),
        .wr_en     (wr_en),
        .wr_op     (wr_op),
        .wr_cpu    (wr_cpu),
        .wr_data   (wr_data),
        .irq_lvl_o (irq_lvl_o)
    );

    task automatic chk(input string req, input int cpu, input logic [15:0] exp);
        logic [15:0] act;
        act = irq_lvl_o[cpu*16 +: 16];
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cpu%0d: actual %h expected %h", req, cpu, act, exp);
        end
    endtask

    task automatic set_dev(input int j, input logic v);
        @(negedge clk);
        dev_irq[j] = v;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] op, input int cpu, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_op = op;
        wr_cpu = CW'(cpu);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCPU; c++) chk("R1 reset", c, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NCPU; c++) chk("R1 after reset", c, 16'h0000);
    endtask

    task automatic t_route();
        @(negedge clk);
        dev_irq[3] = 1'b1;
        #1 chk("R12 not before edge", 0, 16'h0000);
        @(negedge clk);
        chk("R2 R12 source3 level3", 0, 16'h0008);
        set_dev(17, 1'b1);
        chk("R2 source17 level1", 0, 16'h000a);
        chk("R11 cpu1 idle", 1, 16'h0000);
    endtask

    task automatic t_multi();
        set_dev(20, 1'b1);
        chk("R3 levels 1,3,4", 0, 16'h001a);
        set_dev(4, 1'b1);
        set_dev(20, 1'b0);
        chk("R3 R4 shared level held", 0, 16'h001a);
        set_dev(4, 1'b0);
        chk("R4 level dropped", 0, 16'h000a);
    endtask

    task automatic t_level0();
        set_dev(0, 1'b1);
        chk("R5 level0 source", 0, 16'h000a);
        set_dev(16, 1'b1);
        chk("R5 level0 source16", 0, 16'h000a);
        set_dev(0, 1'b0);
        set_dev(16, 1'b0);
        set_dev(8, 1'b1);
        chk("R1 source8 disabled at reset", 0, 16'h000a);
        set_dev(8, 1'b0);
    endtask

    task automatic t_target();
        wr(2'd3, 0, 32'd6);
        chk("R8 old target cleared", 0, 16'h0000);
        chk("R8 masked target 2", 2, 16'h000a);
        wr(2'd3, 0, 32'd5);
        chk("R8 masked target 1", 1, 16'h000a);
        chk("R11 cpu2 soft only", 2, 16'h0000);
    endtask

    task automatic t_soft();
        wr(2'd1, 3, 32'h0006_0000);
        chk("R9 soft levels 1,2", 3, 16'h0006);
        wr(2'd1, 3, 32'h0001_ffff);
        chk("R9 low bits ignored", 3, 16'h0006);
        wr(2'd0, 3, 32'h0002_0000);
        chk("R10 clear level1", 3, 16'h0004);
        wr(2'd1, 1, 32'h8000_0000);
        chk("R9 soft on target", 1, 16'h800a);
        wr(2'd0, 1, 32'h0001_ffff);
        chk("R10 low bits ignored", 1, 16'h800a);
        wr(2'd0, 1, 32'h8000_0000);
        chk("R10 clear level15", 1, 16'h000a);
        chk("R11 cpu3 own soft", 3, 16'h0004);
    endtask

    task automatic t_disable();
        wr(2'd2, 0, 32'h0000_0008);
        chk("R6 disable source3", 1, 16'h0002);
        set_dev(3, 1'b0);
        set_dev(3, 1'b1);
        chk("R6 disabled rerise", 1, 16'h0002);
        wr(2'd3, 0, 32'd0);
        chk("R8 back to cpu0", 0, 16'h0002);
        chk("R8 cpu1 cleared", 1, 16'h0000);
    endtask

    task automatic t_global();
        wr(2'd2, 0, 32'h8000_0000);
        chk("R7 master blocked", 0, 16'h0000);
        set_dev(5, 1'b1);
        chk("R7 new source blocked", 0, 16'h0000);
        chk("R7 soft kept", 3, 16'h0004);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_route();
        t_multi();
        t_level0();
        t_target();
        t_soft();
        t_disable();
        t_global();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule